// File: doc/BRIEF.md
# Timer/Counter with Capture-Compare Channels

This block is a general-purpose 32-bit timer/counter controlled over a simple 32-bit register bus. It has two ways of counting. In timer mode the count advances on a divided reference tick. The reference is picked from two enable strobes, one fast and one slow, and a power-of-two prescaler divides the chosen strobe. In counter mode the count advances once for each count task that software writes. The count can be started, stopped, cleared and captured at any time. A stop holds the count where it is, and the next start continues from that value.

Each of the four channels has one capture/compare register, and that register serves two purposes. A capture task copies the live count into it. In every other cycle it is the value the count is compared against. When an increment takes the count to a channel's register value, the channel's compare event latches. The single interrupt output is raised while any latched event has its enable bit set.

The bus is a single-cycle write strobe with a combinational read of the addressed word. All registers are 32-bit words at word-aligned offsets: TASK 0x00, MODE 0x04, EVT 0x08, IEN 0x0C, and channel n at 0x10+4n.

Top module: `tc_top`

## Requirements
- R1: After reset, TASK reads 0 (stopped), MODE reads 0x2 (timer mode, 32-bit width, fast reference, divide by 1), EVT and IEN read 0, every channel register reads 0, and irq is low.
- R2: TASK write bit 0 starts the count and bit 1 stops it. While stopped the count holds, and a later start resumes from the held value. TASK read bit 0 gives the running state.
- R3: In timer mode (MODE bit 0 = 0), a running count advances once per 2^N strobes of the selected reference. MODE bit 2 selects the reference (0 = fast, 1 = slow). N is MODE bits 11:8, and values above 9 act as 9.
- R4: In counter mode (MODE bit 0 = 1), a running count advances by one for each TASK write with bit 2 set. Reference strobes have no effect.
- R5: A TASK write with bit 3 set zeroes the count without changing the running state. It takes priority over an increment in the same cycle.
- R6: A TASK write with bit 4+n set copies the current count into channel n's register. Channel registers can also be written and read over the bus.
- R7: When an increment makes the count equal to channel n's register, EVT bit n sets. It stays set until an EVT write carries 0 in bit n. Writing 1 leaves it unchanged.
- R8: irq is high exactly when some EVT bit n and IEN bit n are both set.
- R9: MODE bit 1 selects the count width (1 = 32 bits, 0 = 16 bits). In 16-bit mode an increment from 0xFFFF wraps silently to 0, and the compare uses the low 16 bits.
- R10: A TASK write that sets both start and stop leaves the count stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the word being accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ref_fast_stb | input | 1 | Fast reference enable strobe |
| ref_slow_stb | input | 1 | Slow reference enable strobe |
| irq | output | 1 | Interrupt request |

## Verification
A wrong count shows up at the next capture as a channel register value that differs from the expected number of prescaled strobes or count tasks. It also shows as a compare event that is missing, early or late, and the EVT and irq outputs reveal that in the same cycle as the increment. Faults in the prescaler phase or the wrap point appear within one division period or one wrap. A stuck run flag appears as a frozen capture value after the first start.

// File: rtl/tc_pkg.sv
package tc_pkg;

    // Word offsets (byte address >> 2)
    localparam int unsigned WORD_TASK = 0;
    localparam int unsigned WORD_MODE = 1;
    localparam int unsigned WORD_EVT  = 2;
    localparam int unsigned WORD_IEN  = 3;
    localparam int unsigned WORD_CC0  = 4;

    // Task bit positions
    localparam int unsigned TB_START = 0;
    localparam int unsigned TB_STOP  = 1;
    localparam int unsigned TB_COUNT = 2;
    localparam int unsigned TB_CLEAR = 3;
    localparam int unsigned TB_CAP0  = 4;

    typedef enum logic {
        CNT_MODE_TIMER   = 1'b0,
        CNT_MODE_COUNTER = 1'b1
    } cnt_mode_e;

endpackage

// File: rtl/tc_prescaler.sv
module tc_prescaler #(
    parameter int unsigned PS_MAX = 9,
    localparam int unsigned PS_W  = $clog2(PS_MAX + 1),
    localparam int unsigned DIV_W = PS_MAX + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            ref_stb,
    input  logic [3:0]      shift,
    input  logic            restart,
    output logic            tick
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } ps_state_t;

    ps_state_t st_d, st_q;
    logic [PS_W-1:0]  shift_eff;
    logic [DIV_W-1:0] limit;

    always_comb begin
        st_d = st_q;
        if (32'(shift) > PS_MAX) shift_eff = PS_W'(PS_MAX);
        else                     shift_eff = PS_W'(shift);
        limit = (DIV_W'(1) << shift_eff) - DIV_W'(1);
        tick  = enable && ref_stb && (st_q.div >= limit);
        if (restart)             st_d.div = '0;
        else if (tick)           st_d.div = '0;
        else if (enable && ref_stb) st_d.div = st_q.div + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PRE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (st_q.div == '0)); // R3

    AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_stb && !restart) |=> $stable(st_q.div)); // R3

endmodule

// File: rtl/tc_core.sv
module tc_core #(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned NARROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             clear,
    input  logic             inc_req,
    input  logic             wide,
    output logic             running,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_nxt,
    output logic             bump
);

    localparam logic [CNT_W-1:0] NARROW_MASK = CNT_W'((64'd1 << NARROW_W) - 64'd1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } core_state_t;

    core_state_t st_d, st_q;
    logic [CNT_W-1:0] plus_one;

    always_comb begin
        st_d     = st_q;
        plus_one = st_q.cnt + CNT_W'(1);
        if (!wide) plus_one = plus_one & NARROW_MASK;
        bump = st_q.run && inc_req && !clear;
        if (stop)       st_d.run = 1'b0;
        else if (start) st_d.run = 1'b1;
        if (clear)      st_d.cnt = '0;
        else if (bump)  st_d.cnt = plus_one;
        count_nxt = st_d.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign running = st_q.run;
    assign count   = st_q.cnt;

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !clear) |=> $stable(st_q.cnt)); // R2

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st_q.cnt == '0)); // R5

    AST_CLEAR_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !start && !stop) |=> $stable(st_q.run)); // R5

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !st_q.run); // R10

    AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && !wide) |=> ((st_q.cnt & ~NARROW_MASK) == '0)); // R9

endmodule

// File: rtl/tc_channel.sv
module tc_channel #(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned NARROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [CNT_W-1:0] cap_val,
    input  logic             wr_cc,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             bump,
    input  logic [CNT_W-1:0] count_nxt,
    input  logic             wide,
    input  logic             ev_wr,
    input  logic             ev_wr_bit,
    output logic [CNT_W-1:0] cc,
    output logic             ev
);

    typedef struct packed {
        logic [CNT_W-1:0] cc;
        logic             ev;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic match;

    always_comb begin
        st_d = st_q;
        if (wide) match = bump && (count_nxt == st_q.cc);
        else      match = bump && (count_nxt[NARROW_W-1:0] == st_q.cc[NARROW_W-1:0]);
        if (capture)    st_d.cc = cap_val;
        else if (wr_cc) st_d.cc = wr_data;
        if (match)                    st_d.ev = 1'b1;
        else if (ev_wr && !ev_wr_bit) st_d.ev = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cc = st_q.cc;
    assign ev = st_q.ev;

    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (st_q.cc == $past(cap_val))); // R6

    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ev && !ev_wr) |=> st_q.ev); // R7

    AST_EVT_NEEDS_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ev && !bump) |=> !st_q.ev); // R7

endmodule

// File: rtl/tc_top.sv
module tc_top #(
    parameter int unsigned NUM_CH   = 4,
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned NARROW_W = 16,
    parameter int unsigned PS_MAX   = 9,
    parameter int unsigned ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ref_fast_stb,
    input  logic              ref_slow_stb,
    output logic              irq
);
    import tc_pkg::*;

    localparam int unsigned WORD_W = ADDR_W - 2;

    typedef struct packed {
        cnt_mode_e        mode;
        logic             wide;
        logic             ref_slow;
        logic [3:0]       shift;
        logic [NUM_CH-1:0] ien;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              wr_task, wr_mode, wr_evt, wr_ien;
    logic [NUM_CH-1:0] wr_cc;
    logic [NUM_CH-1:0] cap;
    logic              t_start, t_stop, t_count, t_clear;
    logic              ref_stb, tick, inc_req, running, bump;
    logic [CNT_W-1:0]  count, count_nxt;
    logic [CNT_W-1:0]  cc [NUM_CH];
    logic [NUM_CH-1:0] ev;

    // Bus decode
    always_comb begin
        word    = bus_addr[ADDR_W-1:2];
        aligned = (bus_addr[1:0] == 2'b00);
        wr_task = bus_wr && aligned && (32'(word) == WORD_TASK);
        wr_mode = bus_wr && aligned && (32'(word) == WORD_MODE);
        wr_evt  = bus_wr && aligned && (32'(word) == WORD_EVT);
        wr_ien  = bus_wr && aligned && (32'(word) == WORD_IEN);
        t_start = wr_task && bus_wdata[TB_START];
        t_stop  = wr_task && bus_wdata[TB_STOP];
        t_count = wr_task && bus_wdata[TB_COUNT];
        t_clear = wr_task && bus_wdata[TB_CLEAR];
        for (int n = 0; n < NUM_CH; n++) begin
            wr_cc[n] = bus_wr && aligned && (32'(word) == WORD_CC0 + n);
            cap[n]   = wr_task && bus_wdata[TB_CAP0 + n];
        end
    end

    // Configuration registers
    always_comb begin
        cfg_d = cfg_q;
        if (wr_mode) begin
            cfg_d.mode     = cnt_mode_e'(bus_wdata[0]);
            cfg_d.wide     = bus_wdata[1];
            cfg_d.ref_slow = bus_wdata[2];
            cfg_d.shift    = bus_wdata[11:8];
        end
        if (wr_ien) cfg_d.ien = bus_wdata[NUM_CH-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q          <= '0;
            cfg_q.wide     <= 1'b1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // Tick source
    assign ref_stb = cfg_q.ref_slow ? ref_slow_stb : ref_fast_stb;

    tc_prescaler #(.PS_MAX(PS_MAX)) u_ps (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (running && (cfg_q.mode == CNT_MODE_TIMER)),
        .ref_stb (ref_stb),
        .shift   (cfg_q.shift),
        .restart (t_stop || t_clear),
        .tick    (tick)
    );

    assign inc_req = (cfg_q.mode == CNT_MODE_TIMER) ? tick : t_count;

    tc_core #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (t_start),
        .stop      (t_stop),
        .clear     (t_clear),
        .inc_req   (inc_req),
        .wide      (cfg_q.wide),
        .running   (running),
        .count     (count),
        .count_nxt (count_nxt),
        .bump      (bump)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tc_channel #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .capture   (cap[g]),
            .cap_val   (count),
            .wr_cc     (wr_cc[g]),
            .wr_data   (bus_wdata[CNT_W-1:0]),
            .bump      (bump),
            .count_nxt (count_nxt),
            .wide      (cfg_q.wide),
            .ev_wr     (wr_evt),
            .ev_wr_bit (bus_wdata[g]),
            .cc        (cc[g]),
            .ev        (ev[g])
        );
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (32'(word) == WORD_TASK)      bus_rdata[0] = running;
            else if (32'(word) == WORD_MODE) begin
                bus_rdata[0]    = cfg_q.mode;
                bus_rdata[1]    = cfg_q.wide;
                bus_rdata[2]    = cfg_q.ref_slow;
                bus_rdata[11:8] = cfg_q.shift;
            end
            else if (32'(word) == WORD_EVT)  bus_rdata[NUM_CH-1:0] = ev;
            else if (32'(word) == WORD_IEN)  bus_rdata[NUM_CH-1:0] = cfg_q.ien;
            else begin
                for (int n = 0; n < NUM_CH; n++)
                    if (32'(word) == WORD_CC0 + n) bus_rdata[CNT_W-1:0] = cc[n];
            end
        end
    end

    assign irq = |(ev & cfg_q.ien);

    AST_COUNTER_IGNORES_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == CNT_MODE_COUNTER && !t_count && !t_clear) |=> $stable(count)); // R4

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.ien == '0) |-> !irq); // R8

endmodule

// File: tb/tb_tc_top.sv
module tb_tc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ref_fast_stb = 1'b0;
    logic        ref_slow_stb = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tc_top dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ref_fast_stb(ref_fast_stb), .ref_slow_stb(ref_slow_stb), .irq(irq)
    );

    localparam logic [7:0] A_TASK = 8'h00, A_MODE = 8'h04, A_EVT = 8'h08, A_IEN = 8'h0C;
    localparam logic [31:0] T_START = 32'h1, T_STOP = 32'h2, T_COUNT = 32'h4, T_CLEAR = 32'h8;

    function automatic logic [7:0] cc_addr(int n);
        return 8'(8'h10 + 4 * n);
    endfunction

    function automatic logic [31:0] cap_bit(int n);
        return 32'h10 << n;
    endfunction

    function automatic int exp_ticks(int strobes, int n);
        int e;
        e = (n > 9) ? 9 : n;
        return strobes >> e;
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic strobes(bit slow, int cnt);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            if (slow) ref_slow_stb = 1'b1; else ref_fast_stb = 1'b1;
            @(negedge clk);
            ref_slow_stb = 1'b0; ref_fast_stb = 1'b0;
        end
    endtask

    task automatic count_tasks(int cnt);
        for (int i = 0; i < cnt; i++) wr(A_TASK, T_COUNT);
    endtask

    task automatic cap_check(string req, logic [31:0] exp);
        logic [31:0] v;
        wr(A_TASK, cap_bit(0));
        rd(cc_addr(0), v);
        check(req, v, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_TASK, v); check("R1 task", v, 32'h0);
        rd(A_MODE, v); check("R1 mode", v, 32'h2);
        rd(A_EVT, v);  check("R1 evt", v, 32'h0);
        rd(A_IEN, v);  check("R1 ien", v, 32'h0);
        for (int n = 0; n < 4; n++) begin
            rd(cc_addr(n), v); check("R1 cc", v, 32'h0);
        end
        check("R1 irq", {31'h0, irq}, 32'h0);

        // R4 counter mode
        wr(A_MODE, 32'h3);
        wr(A_TASK, T_START);
        rd(A_TASK, v); check("R2 running", v, 32'h1);
        count_tasks(5);
        cap_check("R4 counted", 32'd5);
        strobes(0, 6); strobes(1, 6);
        cap_check("R4 strobes ignored", 32'd5);

        // R2 stop holds, start resumes
        wr(A_TASK, T_STOP);
        count_tasks(3);
        cap_check("R2 held", 32'd5);
        wr(A_TASK, T_START);
        count_tasks(2);
        cap_check("R2 resumed", 32'd7);

        // R5 clear keeps running, beats increment
        wr(A_TASK, T_CLEAR);
        rd(A_TASK, v); check("R5 run kept", v, 32'h1);
        cap_check("R5 zeroed", 32'd0);
        count_tasks(4);
        wr(A_TASK, T_CLEAR | T_COUNT);
        cap_check("R5 clear wins", 32'd0);

        // R6 capture into another channel, bus write of channel
        count_tasks(9);
        wr(A_TASK, cap_bit(3));
        rd(cc_addr(3), v); check("R6 cap ch3", v, 32'd9);
        wr(cc_addr(2), 32'hDEAD_BEEF);
        rd(cc_addr(2), v); check("R6 bus wr", v, 32'hDEAD_BEEF);

        // R10 stop wins
        wr(A_TASK, T_START | T_STOP);
        rd(A_TASK, v); check("R10 stopped", v, 32'h0);

        // R7/R8 compare events
        wr(cc_addr(1), 32'd3);
        wr(A_TASK, T_CLEAR | T_START);
        count_tasks(3);
        rd(A_EVT, v); check("R7 ev set", v & 32'h2, 32'h2);
        check("R8 irq masked", {31'h0, irq}, 32'h0);
        wr(A_IEN, 32'h2);
        #1 check("R8 irq on", {31'h0, irq}, 32'h1);
        wr(A_EVT, 32'hF);
        rd(A_EVT, v); check("R7 write1 keeps", v & 32'h2, 32'h2);
        wr(A_EVT, 32'hD);
        rd(A_EVT, v); check("R7 write0 clears", v & 32'h2, 32'h0);
        check("R8 irq off", {31'h0, irq}, 32'h0);
        count_tasks(2);
        rd(A_EVT, v); check("R7 no refire", v & 32'h2, 32'h0);
        wr(A_EVT, 32'h0); wr(A_IEN, 32'h0);

        // R3 prescaler, fast ref N=2
        wr(A_MODE, 32'h0000_0202);
        wr(A_TASK, T_CLEAR | T_START);
        strobes(0, 8);
        cap_check("R3 div4", 32'd2);
        strobes(1, 8);
        cap_check("R3 slow ignored", 32'd2);
        wr(A_TASK, T_STOP);
        // slow ref, N=12 -> 9
        wr(A_MODE, 32'h0000_0C06);
        wr(A_TASK, T_CLEAR | T_START);
        strobes(1, 511);
        cap_check("R3 clamp 511", 32'd0);
        strobes(1, 1);
        cap_check("R3 clamp 512", 32'd1);
        wr(A_TASK, T_STOP);

        // R3 random prescale trials
        for (int t = 0; t < 20; t++) begin
            int n, s;
            bit sl;
            n = int'($urandom_range(0, 3));
            s = int'($urandom_range(0, 40));
            sl = 1'($urandom_range(0, 1));
            wr(A_MODE, 32'(n << 8) | 32'h2 | (32'(sl) << 2));
            wr(A_TASK, T_CLEAR | T_START);
            strobes(sl, s);
            wr(A_TASK, T_STOP);
            cap_check("R3 random", 32'(exp_ticks(s, n)));
        end

        // R9 16-bit wrap with compare at zero
        wr(A_MODE, 32'h0);
        wr(cc_addr(2), 32'h0001_0000);
        wr(A_EVT, 32'h0);
        wr(A_TASK, T_CLEAR | T_START);
        @(negedge clk);
        ref_fast_stb = 1'b1;
        repeat (65535) @(negedge clk);
        ref_fast_stb = 1'b0;
        cap_check("R9 at max", 32'h0000_FFFF);
        rd(A_EVT, v); check("R9 no early ev", v & 32'h4, 32'h0);
        strobes(0, 1);
        cap_check("R9 wrapped", 32'h0);
        rd(A_EVT, v); check("R9 low16 compare", v & 32'h4, 32'h4);
        // R9 32-bit width does not wrap at 16 bits
        wr(A_TASK, T_STOP);
        wr(A_MODE, 32'h2);
        wr(A_TASK, T_CLEAR | T_START);
        strobes(0, 3);
        cap_check("R9 wide count", 32'd3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule